// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block holds a small byte-addressed register store that software views at three widths: single bytes, 16-bit words and 32-bit double words. A wider register is a view onto a run of consecutive bytes, not separate storage. The most significant byte of a word or double word sits at the lowest byte index. A write through one view therefore shows up at once through every other view that overlaps it.

One write port takes a width code, an index and data, and writes 1, 2 or 4 bytes. Two independent read ports each take their own width code and index, so an instruction's source and destination operands can be fetched together. Every port checks its index against the legal set for its width and raises an error flag when the index is illegal. Each read port also reports whether the index falls in the narrow byte class used for indirect pointers, which holds only the first two bytes.

A separate helper takes a 16-bit word and a memory address and writes the word to a byte-wide memory port as two byte writes, high byte first.

Top module: `mw_regfile`

## Requirements
- R1: Width code 00 selects a byte access. Legal byte indices are 0 to 15. A byte read returns the byte in bits 7:0, and bits 31:8 are zero.
- R2: Width code 01 selects a word access. Word j covers byte j (bits 15:8) and byte j+1 (bits 7:0). A word read returns zero in bits 31:16.
- R3: Legal word indices are the even numbers 0 through 30. Any other word index raises the error flag.
- R4: Width code 10 selects a double-word access. Double word k covers bytes k to k+3, with byte k in bits 31:24 and byte k+3 in bits 7:0.
- R5: Legal double-word indices are the multiples of four from 0 to 28, plus 56 and 60. For an illegal index, or for width code 11, wr_err is raised and storage is left unchanged. The same cases raise rdN_err and make the read data zero.
- R6: All views alias one store. A write through one width is visible through every overlapping view of another width.
- R7: rdN_ptr_ok is 1 only for a byte access (code 00) at index 0 or 1.
- R8: Writes take effect on the rising edge when wr_en is 1. Reads are combinational, so a read in the same cycle as a write returns the old contents.
- R9: A synchronous active-high reset clears every byte to 00h.
- R10: After st_go is sampled, the store helper drives mem_we for two consecutive cycles. The first cycle puts the high byte at st_addr. The second puts the low byte at st_addr+1.
- R11: st_done pulses for exactly one cycle, in the cycle after the second byte write. st_busy is 1 while the two writes are in progress.
- R12: The two read ports are independent. Each returns its own view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_width | input | 2 | Write width code |
| wr_idx | input | 6 | Write byte index |
| wr_data | input | 32 | Write data, right-aligned |
| wr_err | output | 1 | Write requested with an illegal index or width |
| rd0_width | input | 2 | Read port 0 width code |
| rd0_idx | input | 6 | Read port 0 index |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 illegal index or width |
| rd0_ptr_ok | output | 1 | Read port 0 index is in the pointer byte class |
| rd1_width | input | 2 | Read port 1 width code |
| rd1_idx | input | 6 | Read port 1 index |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 illegal index or width |
| rd1_ptr_ok | output | 1 | Read port 1 index is in the pointer byte class |
| st_go | input | 1 | Start a word store |
| st_addr | input | 16 | Memory address for the high byte |
| st_word | input | 16 | Word to store |
| mem_we | output | 1 | Byte memory write strobe |
| mem_addr | output | 16 | Byte memory address |
| mem_data | output | 8 | Byte memory data |
| st_busy | output | 1 | Store in progress |
| st_done | output | 1 | One-cycle pulse after the second byte write |

## Verification
The bench checks byte order through mixed-width reads after wide writes. A little-endian design would return swapped bytes, for example B6h instead of A3h from byte 0 after a word write. It targets the gap in the double-word range: indices 32 and 36 must be rejected while 56 and 60 are accepted, and a design that only tested alignment would accept the gap. Misaligned word and double-word writes are followed by reads of the neighbouring registers, which would show any stray byte update. The bench also checks a read in the same cycle as a write, which must not return the new value, and the exact cycle in which each store-helper byte appears.

// File: rtl/mw_rf_pkg.sv
package mw_rf_pkg;
    typedef enum logic [1:0] {
        WID_BYTE  = 2'b00,
        WID_WORD  = 2'b01,
        WID_DWORD = 2'b10,
        WID_BAD   = 2'b11
    } wid_e;

    function automatic int unsigned wid_bytes(wid_e w);
        case (w)
            WID_BYTE:  return 1;
            WID_WORD:  return 2;
            WID_DWORD: return 4;
            default:   return 0;
        endcase
    endfunction
endpackage

// File: rtl/mw_rf_idx_check.sv
module mw_rf_idx_check
    import mw_rf_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int BYTE_CNT   = 16,
    parameter int WORD_MAX   = 30,
    parameter int DW_LOW_MAX = 28,
    parameter int DW_HI_A    = 56,
    parameter int DW_HI_B    = 60
) (
    input  wid_e             width,
    input  logic [IDX_W-1:0] idx,
    output logic             legal
);
    localparam logic [IDX_W-1:0] BYTE_LIM_C = IDX_W'(BYTE_CNT);
    localparam logic [IDX_W-1:0] WORD_MAX_C = IDX_W'(WORD_MAX);
    localparam logic [IDX_W-1:0] DW_LOW_C   = IDX_W'(DW_LOW_MAX);
    localparam logic [IDX_W-1:0] DW_A_C     = IDX_W'(DW_HI_A);
    localparam logic [IDX_W-1:0] DW_B_C     = IDX_W'(DW_HI_B);

    always_comb begin
        case (width)
            WID_BYTE:  legal = (idx < BYTE_LIM_C);
            WID_WORD:  legal = !idx[0] && (idx <= WORD_MAX_C);
            WID_DWORD: legal = (idx[1:0] == 2'b00) &&
                               ((idx <= DW_LOW_C) || (idx == DW_A_C) || (idx == DW_B_C));
            default:   legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mw_rf_read_port.sv
module mw_rf_read_port
    import mw_rf_pkg::*;
#(
    parameter int NUM_BYTES = 64,
    parameter int IDX_W     = 6,
    parameter int PTR_CNT   = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_BYTES-1:0][7:0]     bytes,
    input  wid_e                          width,
    input  logic [IDX_W-1:0]              idx,
    output logic [31:0]                   rdata,
    output logic                          err,
    output logic                          ptr_ok
);
    localparam logic [IDX_W-1:0] PTR_LIM_C = IDX_W'(PTR_CNT);

    logic legal;
    logic [3:0][7:0] win;

    mw_rf_idx_check #(.IDX_W(IDX_W)) u_chk (
        .width (width),
        .idx   (idx),
        .legal (legal)
    );

    // Gather four bytes starting at idx; index wraps, result is masked when illegal
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            win[3-k] = bytes[idx + IDX_W'(k)];
        end
    end

    always_comb begin
        rdata = '0;
        if (legal) begin
            case (width)
                WID_BYTE:  rdata = {24'h0, win[3]};
                WID_WORD:  rdata = {16'h0, win[3], win[2]};
                WID_DWORD: rdata = win;
                default:   rdata = '0;
            endcase
        end
    end

    assign err    = !legal;
    assign ptr_ok = (width == WID_BYTE) && (idx < PTR_LIM_C);

    assert_rd_err_zero_R5: assert property (@(posedge clk) disable iff (rst)
        err |-> (rdata == 32'h0));
    assert_byte_zero_ext_R1: assert property (@(posedge clk) disable iff (rst)
        (!err && width == WID_BYTE) |-> (rdata[31:8] == 24'h0));
    assert_word_zero_ext_R2: assert property (@(posedge clk) disable iff (rst)
        (!err && width == WID_WORD) |-> (rdata[31:16] == 16'h0));
    assert_ptr_is_legal_byte_R7: assert property (@(posedge clk) disable iff (rst)
        ptr_ok |-> !err);
endmodule

// File: rtl/mw_rf_word_store.sv
module mw_rf_word_store #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       word,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              busy,
    output logic              done
);
    typedef enum logic [1:0] { SS_IDLE, SS_HI, SS_LO } ss_e;

    typedef struct packed {
        ss_e              state;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       word;
        logic              done;
    } ss_t;

    ss_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.state)
            SS_IDLE: if (go) begin
                s_d.addr  = addr;
                s_d.word  = word;
                s_d.state = SS_HI;
            end
            SS_HI:   s_d.state = SS_LO;
            SS_LO: begin
                s_d.state = SS_IDLE;
                s_d.done  = 1'b1;
            end
            default: s_d.state = SS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign mem_we   = (s_q.state == SS_HI) || (s_q.state == SS_LO);
    assign mem_addr = (s_q.state == SS_LO) ? s_q.addr + ADDR_W'(1) : s_q.addr;
    assign mem_data = (s_q.state == SS_LO) ? s_q.word[7:0] : s_q.word[15:8];
    assign busy     = mem_we;
    assign done     = s_q.done;

    assert_low_at_next_addr_R10: assert property (@(posedge clk) disable iff (rst)
        (s_q.state == SS_LO) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
    assert_done_after_low_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_we) && !mem_we));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/mw_regfile.sv
module mw_regfile
    import mw_rf_pkg::*;
#(
    parameter int NUM_BYTES = 64,
    parameter int ADDR_W    = 16,
    localparam int IDX_W    = $clog2(NUM_BYTES),
    localparam int NUM_RD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_width,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    output logic              wr_err,
    input  logic [1:0]        rd0_width,
    input  logic [IDX_W-1:0]  rd0_idx,
    output logic [31:0]       rd0_data,
    output logic              rd0_err,
    output logic              rd0_ptr_ok,
    input  logic [1:0]        rd1_width,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic [31:0]       rd1_data,
    output logic              rd1_err,
    output logic              rd1_ptr_ok,
    input  logic              st_go,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [15:0]       st_word,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              st_busy,
    output logic              st_done
);
    typedef struct packed {
        logic [NUM_BYTES-1:0][7:0] bytes;
    } rf_t;

    rf_t  rf_d, rf_q;
    wid_e w_wid;
    logic w_ok;

    assign w_wid = wid_e'(wr_width);

    mw_rf_idx_check #(.IDX_W(IDX_W)) u_wchk (
        .width (w_wid),
        .idx   (wr_idx),
        .legal (w_ok)
    );

    always_comb begin
        int unsigned nb;
        rf_d = rf_q;
        nb   = wid_bytes(w_wid);
        if (wr_en && w_ok) begin
            for (int k = 0; k < 4; k++) begin
                if (k < int'(nb)) begin
                    rf_d.bytes[wr_idx + IDX_W'(k)] = wr_data[8*(int'(nb)-1-k) +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rf_q <= '0;
        else     rf_q <= rf_d;
    end

    assign wr_err = wr_en && !w_ok;

    logic [NUM_RD-1:0][1:0]       p_wid;
    logic [NUM_RD-1:0][IDX_W-1:0] p_idx;
    logic [NUM_RD-1:0][31:0]      p_data;
    logic [NUM_RD-1:0]            p_err;
    logic [NUM_RD-1:0]            p_ptr;

    assign p_wid[0] = rd0_width;
    assign p_wid[1] = rd1_width;
    assign p_idx[0] = rd0_idx;
    assign p_idx[1] = rd1_idx;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        mw_rf_read_port #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_rd (
            .clk    (clk),
            .rst    (rst),
            .bytes  (rf_q.bytes),
            .width  (wid_e'(p_wid[p])),
            .idx    (p_idx[p]),
            .rdata  (p_data[p]),
            .err    (p_err[p]),
            .ptr_ok (p_ptr[p])
        );
    end

    assign rd0_data   = p_data[0];
    assign rd0_err    = p_err[0];
    assign rd0_ptr_ok = p_ptr[0];
    assign rd1_data   = p_data[1];
    assign rd1_err    = p_err[1];
    assign rd1_ptr_ok = p_ptr[1];

    mw_rf_word_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .go       (st_go),
        .addr     (st_addr),
        .word     (st_word),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .busy     (st_busy),
        .done     (st_done)
    );

    assert_illegal_write_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> $stable(rf_q));
    assert_idle_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rf_q));
    assert_word_even_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && w_wid == WID_WORD) |-> !wr_idx[0]);
    assert_dword_range_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_err && w_wid == WID_DWORD) |->
        (wr_idx[1:0] == 2'b00 && (wr_idx <= IDX_W'(28) || wr_idx >= IDX_W'(56))));
endmodule

// File: tb/test_mw_regfile.sv
module test_mw_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_width;
    logic [5:0]  wr_idx;
    logic [31:0] wr_data;
    logic        wr_err;
    logic [1:0]  rd0_width, rd1_width;
    logic [5:0]  rd0_idx, rd1_idx;
    logic [31:0] rd0_data, rd1_data;
    logic        rd0_err, rd1_err, rd0_ptr_ok, rd1_ptr_ok;
    logic        st_go;
    logic [15:0] st_addr, st_word;
    logic        mem_we, st_busy, st_done;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mw_regfile i_mw_regfile (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_width(wr_width), .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
        .rd0_width(rd0_width), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd0_ptr_ok(rd0_ptr_ok),
        .rd1_width(rd1_width), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_err(rd1_err),
        .rd1_ptr_ok(rd1_ptr_ok),
        .st_go(st_go), .st_addr(st_addr), .st_word(st_word),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .st_busy(st_busy), .st_done(st_done)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        we;
        logic [1:0]  wwid;
        logic [5:0]  widx;
        logic [31:0] wdata;
        logic        exp_werr;
        logic [1:0]  rwid;
        logic [5:0]  ridx;
        logic [31:0] exp_rd;
        logic        exp_rerr;
    } vec_t;

    // width codes: 00 byte, 01 word, 10 dword, 11 illegal
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b01, 6'd0,  32'h0000A3B6, 1'b0, 2'b00, 6'd0,  32'h000000A3, 1'b0}, // R2
        '{1'b0, 2'b00, 6'd0,  32'h0,        1'b0, 2'b00, 6'd1,  32'h000000B6, 1'b0}, // R2 R6
        '{1'b1, 2'b10, 6'd4,  32'h0000C4D7, 1'b0, 2'b10, 6'd4,  32'h0000C4D7, 1'b0}, // R4
        '{1'b0, 2'b00, 6'd0,  32'h0,        1'b0, 2'b00, 6'd6,  32'h000000C4, 1'b0}, // R4 R6
        '{1'b0, 2'b00, 6'd0,  32'h0,        1'b0, 2'b01, 6'd6,  32'h0000C4D7, 1'b0}, // R6
        '{1'b0, 2'b00, 6'd0,  32'h0,        1'b0, 2'b10, 6'd0,  32'hA3B60000, 1'b0}, // R6
        '{1'b1, 2'b00, 6'd15, 32'h0000005A, 1'b0, 2'b01, 6'd14, 32'h0000005A, 1'b0}, // R1
        '{1'b1, 2'b10, 6'd56, 32'h11223344, 1'b0, 2'b10, 6'd56, 32'h11223344, 1'b0}, // R5
        '{1'b1, 2'b10, 6'd60, 32'hDEADBEEF, 1'b0, 2'b10, 6'd60, 32'hDEADBEEF, 1'b0}, // R5
        '{1'b1, 2'b10, 6'd2,  32'hFFFFFFFF, 1'b1, 2'b10, 6'd0,  32'hA3B60000, 1'b0}, // R5
        '{1'b1, 2'b01, 6'd3,  32'h0000FFFF, 1'b1, 2'b10, 6'd0,  32'hA3B60000, 1'b0}, // R3
        '{1'b1, 2'b01, 6'd30, 32'h0000CAFE, 1'b0, 2'b01, 6'd30, 32'h0000CAFE, 1'b0}, // R3
        '{1'b1, 2'b00, 6'd16, 32'h00000077, 1'b1, 2'b00, 6'd16, 32'h00000000, 1'b1}, // R1
        '{1'b1, 2'b10, 6'd28, 32'h01020304, 1'b0, 2'b01, 6'd30, 32'h00000304, 1'b0}, // R4 R6
        '{1'b1, 2'b01, 6'd2,  32'h0000BEEF, 1'b0, 2'b10, 6'd0,  32'hA3B6BEEF, 1'b0}, // R2
        '{1'b1, 2'b10, 6'd32, 32'h99999999, 1'b1, 2'b10, 6'd36, 32'h00000000, 1'b1}, // R5
        '{1'b1, 2'b11, 6'd0,  32'h12345678, 1'b1, 2'b11, 6'd0,  32'h00000000, 1'b1}  // R5
    };

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_width = 0; wr_idx = 0; wr_data = 0;
        rd0_width = 0; rd0_idx = 0; rd1_width = 0; rd1_idx = 0;
        st_go = 0; st_addr = 0; st_word = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        rd0_width = 2'b10; rd0_idx = 6'd0; rd1_width = 2'b10; rd1_idx = 6'd60;
        #1;
        check("R9 dword0 after reset", rd0_data, 32'h0);
        check("R9 dword60 after reset", rd1_data, 32'h0);
        check("R11 idle not busy", {31'h0, st_busy}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_width = VECS[i].wwid;
            wr_idx = VECS[i].widx; wr_data = VECS[i].wdata;
            #1;
            check($sformatf("R5 wr_err vec %0d", i), {31'h0, wr_err}, {31'h0, VECS[i].exp_werr});
            @(negedge clk);
            wr_en = 1'b0;
            rd0_width = VECS[i].rwid; rd0_idx = VECS[i].ridx;
            #1;
            check($sformatf("R6 read vec %0d", i), rd0_data, VECS[i].exp_rd);
            check($sformatf("R5 rd_err vec %0d", i), {31'h0, rd0_err}, {31'h0, VECS[i].exp_rerr});
        end

        // R8: read during write shows old contents
        @(negedge clk);
        wr_en = 1'b1; wr_width = 2'b10; wr_idx = 6'd8; wr_data = 32'h55667788;
        rd0_width = 2'b10; rd0_idx = 6'd8;
        #1;
        check("R8 old value during write", rd0_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R8 new value after edge", rd0_data, 32'h55667788);

        // R12: independent ports
        rd0_width = 2'b00; rd0_idx = 6'd9;
        rd1_width = 2'b01; rd1_idx = 6'd10;
        #1;
        check("R12 port0 byte9", rd0_data, 32'h00000066);
        check("R12 port1 word10", rd1_data, 32'h00007788);

        // R7: pointer class
        rd0_width = 2'b00; rd0_idx = 6'd1; rd1_width = 2'b00; rd1_idx = 6'd2;
        #1;
        check("R7 ptr byte1", {31'h0, rd0_ptr_ok}, 32'h1);
        check("R7 ptr byte2", {31'h0, rd1_ptr_ok}, 32'h0);
        rd0_width = 2'b01; rd0_idx = 6'd0;
        #1;
        check("R7 ptr word0", {31'h0, rd0_ptr_ok}, 32'h0);

        // R10 R11: word store
        @(negedge clk);
        st_go = 1'b1; st_addr = 16'h0201; st_word = 16'hA3B6;
        @(negedge clk);
        st_go = 1'b0;
        #1;
        check("R10 first we", {31'h0, mem_we}, 32'h1);
        check("R10 first addr", {16'h0, mem_addr}, 32'h0201);
        check("R10 first data", {24'h0, mem_data}, 32'hA3);
        check("R11 busy", {31'h0, st_busy}, 32'h1);
        @(negedge clk);
        #1;
        check("R10 second we", {31'h0, mem_we}, 32'h1);
        check("R10 second addr", {16'h0, mem_addr}, 32'h0202);
        check("R10 second data", {24'h0, mem_data}, 32'hB6);
        check("R11 no early done", {31'h0, st_done}, 32'h0);
        @(negedge clk);
        #1;
        check("R11 done pulse", {31'h0, st_done}, 32'h1);
        check("R10 we dropped", {31'h0, mem_we}, 32'h0);
        @(negedge clk);
        #1;
        check("R11 done one cycle", {31'h0, st_done}, 32'h0);

        // R9: reset clears written contents
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd0_width = 2'b10; rd0_idx = 6'd0; rd1_width = 2'b10; rd1_idx = 6'd56;
        #1;
        check("R9 cleared dword0", rd0_data, 32'h0);
        check("R9 cleared dword56", rd1_data, 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule